// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Contention Guard

This block is an 8-bit serial peripheral port that software runs through three byte registers: control, status and data. A control bit picks master or slave operation. As master, the block divides the system clock to make the serial clock. It shifts the transmit byte out most significant bit first and collects the reply byte from the input line. As slave, it follows a serial clock from an external master, assembles incoming bits, and parks each finished byte in the data register for software to collect. It also returns a preloaded byte on the slave output line.

Two error conditions are tracked. A byte that completes while the previous one is still unread is an overrun. In that case the stored byte is kept and the late one is lost. A low level on the select input while the block is an enabled master means a second master is active. The block then drops out of master mode, turns itself off, releases its clock and data-out pins, and raises a mode-fault flag. Software must acknowledge the flag before the port can be enabled again.

Top module: `spiDuplexCore`

## Requirements
- R1: After reset the control and status registers read 0, `sckOut` is 0 and all three output enables are 0.
- R2: Register addresses: 0 = control (bit0 enable, bit1 master, bits3:2 rate), 1 = status (bit0 done, bit1 overrun, bit2 mode fault), 2 = data (a write supplies the byte to send, a read returns the last received byte). Control reads back what was written.
- R3: A data write while the block is an enabled master with no transfer in progress starts an 8-bit exchange. `sckOut` idles low, `mosiOut` presents bit 7 first and changes after each falling edge, and `misoIn` is sampled on each rising edge. After 8 clocks the received byte is in the data register, the done flag is set, and `sckOut` and `mosiOut` are back at 0.
- R4: Rate codes 0, 1, 2, 3 give a serial clock period of 2, 4, 16 and 32 system clocks, with `sckOut` high for half of each period.
- R5: A data write while a master transfer is in progress is ignored: the bits sent and the length of the transfer are unchanged.
- R6: As an enabled slave with `ssN` low, the block samples `mosiIn` on each rising edge of `sckIn`. It completes a byte on the 8th falling edge, copies it into the data register and sets done. It drives `misoOut` most significant bit first from the byte last written to the data register.
- R7: When a byte completes while done is still set, overrun is set, the data register keeps the unread byte and the new byte is discarded.
- R8: Done and overrun are cleared by a status read followed by a data read.
- R9: A low `ssN` while the block is an enabled master clears the master and enable bits, sets mode fault and aborts any transfer without setting done.
- R10: Any control write made while mode fault is set leaves the enable bit at 0. A status read followed by a control write clears mode fault, and after that an enable write takes effect.
- R11: `sckOe` and `mosiOe` are 1 only while the block is an enabled master. `misoOe` is 1 only while the block is an enabled slave with `ssN` low.
- R12: In slave mode, serial clock edges while `ssN` is high are ignored and complete no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register select |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effects on flag clearing) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| sckIn | input | 1 | Serial clock from an external master |
| sckOut | output | 1 | Serial clock driven in master mode |
| sckOe | output | 1 | Output enable for the serial clock pin |
| mosiIn | input | 1 | Serial data input in slave mode |
| mosiOut | output | 1 | Serial data output in master mode |
| mosiOe | output | 1 | Output enable for the master data-out pin |
| misoIn | input | 1 | Serial data input in master mode |
| misoOut | output | 1 | Serial data output in slave mode |
| misoOe | output | 1 | Output enable for the slave data-out pin |
| ssN | input | 1 | Slave select, active low |

## Verification
The embedded properties hold on every cycle for the contention guard, the enable lock and the overrun rule. A fault cycle must leave master, enable and busy cleared with the flag raised. The enable bit can never sit at 1 beside a raised fault flag. A byte that completes on top of an unread byte must leave the data register unchanged and overrun set. The serial clock must be low whenever no master transfer runs. Bit order, rate timing, the reply byte collected by the master, the slave's returned byte, the flag-clearing sequences and the lock-out after a fault depend on whole transfers, so only the bench scenarios show them.

// File: rtl/spiPkg.sv
package spiPkg;

  localparam int BYTE_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic loadTx;     // load transmit byte into shift register
    logic sampleBit;  // capture the incoming serial bit
    logic shiftBit;   // shift the captured bit in
    logic commitRx;   // copy the finished byte to the receive register
  } spiStrobe_t;

  // Half period of the serial clock in system clocks for a rate code
  function automatic logic [4:0] halfOf(input logic [1:0] rate);
    case (rate)
      2'd0:    halfOf = 5'd1;
      2'd1:    halfOf = 5'd2;
      2'd2:    halfOf = 5'd8;
      default: halfOf = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/spiDatapath.sv
module spiDatapath
  import spiPkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        str,
  input  logic              masterOn,
  input  logic              mstBusy,
  input  logic [DATA_W-1:0] txByte,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  input  logic              ssN,
  output logic              sckRise,
  output logic              sckFall,
  output logic              ssSync,
  output logic [DATA_W-1:0] rxByte,
  output logic              mosiOut,
  output logic              misoOut
);

  localparam int MSB = DATA_W - 1;

  logic [SYNC_N:0]   sckS;
  logic [SYNC_N-1:0] mosiS;
  logic [SYNC_N-1:0] ssS;
  logic [DATA_W-1:0] shiftReg;
  logic              sampleReg;
  logic              inBit;

  // Synchronizers for the externally timed pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS  <= '0;
      mosiS <= '0;
      ssS   <= '1;
    end else begin
      sckS  <= {sckS[SYNC_N-1:0], sckIn};
      mosiS <= {mosiS[SYNC_N-2:0], mosiIn};
      ssS   <= {ssS[SYNC_N-2:0], ssN};
    end
  end

  assign sckRise = sckS[SYNC_N-1] & ~sckS[SYNC_N];
  assign sckFall = ~sckS[SYNC_N-1] & sckS[SYNC_N];
  assign ssSync  = ssS[SYNC_N-1];
  assign inBit   = masterOn ? misoIn : mosiS[SYNC_N-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      sampleReg <= 1'b0;
      rxByte    <= '0;
    end else begin
      if (str.sampleBit) sampleReg <= inBit;
      if (str.loadTx)
        shiftReg <= txByte;
      else if (str.shiftBit)
        shiftReg <= {shiftReg[MSB-1:0], sampleReg};
      if (str.commitRx) rxByte <= {shiftReg[MSB-1:0], sampleReg};
    end
  end

  assign mosiOut = mstBusy & shiftReg[MSB];
  assign misoOut = shiftReg[MSB];

  // R6
  commitOnShift_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.commitRx |-> (str.shiftBit && !str.loadTx));

endmodule

// File: rtl/spiCtrl.sv
module spiCtrl
  import spiPkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [3:0]        ctrlBits,
  input  logic              ssSync,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] rdData,
  output spiStrobe_t        str,
  output logic              spiOn,
  output logic              masterOn,
  output logic              mstBusy,
  output logic              sckOut
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [1:0]       rate;
  logic             doneFlag, ovrFlag, modfFlag, stsArm;
  logic [DIV_W-1:0] divCnt, divLim;
  logic [CNT_W-1:0] bitCnt;

  logic ctrlWr, dataWr, stsRd, dataRd;
  logic slaveAct, faultNow, loadOk, startX, tick;
  logic mRise, mFall, sRise, sFall, lastFall, complete;

  assign ctrlWr = wrEn && (addr == ADDR_CTRL);
  assign dataWr = wrEn && (addr == ADDR_DATA);
  assign stsRd  = rdEn && (addr == ADDR_STAT);
  assign dataRd = rdEn && (addr == ADDR_DATA);

  assign divLim   = DIV_W'(halfOf(rate) - 5'd1);
  assign slaveAct = spiOn && !masterOn && !ssSync;
  assign faultNow = spiOn && masterOn && !ssSync;
  assign loadOk   = dataWr && !mstBusy && (bitCnt == '0);
  assign startX   = loadOk && spiOn && masterOn && !faultNow;
  assign tick     = mstBusy && (divCnt == divLim);
  assign mRise    = tick && !sckOut;
  assign mFall    = tick && sckOut;
  assign sRise    = slaveAct && sckRise;
  assign sFall    = slaveAct && sckFall;
  assign lastFall = (mFall || sFall) && (bitCnt == LAST_BIT);
  assign complete = lastFall && !faultNow;

  always_comb begin
    str.loadTx    = loadOk;
    str.sampleBit = mRise || sRise;
    str.shiftBit  = mFall || sFall;
    str.commitRx  = complete && !doneFlag;
  end

  // Control register and contention guard
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spiOn    <= 1'b0;
      masterOn <= 1'b0;
      rate     <= 2'd0;
    end else if (faultNow) begin
      spiOn    <= 1'b0;
      masterOn <= 1'b0;
    end else if (ctrlWr) begin
      spiOn    <= ctrlBits[0] && !modfFlag;
      masterOn <= ctrlBits[1];
      rate     <= ctrlBits[3:2];
    end
  end

  // Master clock generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mstBusy <= 1'b0;
      sckOut  <= 1'b0;
      divCnt  <= '0;
    end else if (faultNow) begin
      mstBusy <= 1'b0;
      sckOut  <= 1'b0;
      divCnt  <= '0;
    end else if (startX) begin
      mstBusy <= 1'b1;
      sckOut  <= 1'b0;
      divCnt  <= '0;
    end else if (mstBusy) begin
      if (!(spiOn && masterOn)) begin
        mstBusy <= 1'b0;
        sckOut  <= 1'b0;
        divCnt  <= '0;
      end else if (tick) begin
        divCnt <= '0;
        sckOut <= ~sckOut;
        if (lastFall) mstBusy <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // Bit counter shared by both modes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bitCnt <= '0;
    else if (!(mstBusy || slaveAct))
      bitCnt <= '0;
    else if (str.shiftBit)
      bitCnt <= bitCnt + 1'b1;
  end

  // Status flags and clearing sequences
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      ovrFlag  <= 1'b0;
      modfFlag <= 1'b0;
      stsArm   <= 1'b0;
    end else begin
      if (stsRd)
        stsArm <= 1'b1;
      else if (dataRd || ctrlWr)
        stsArm <= 1'b0;
      if (dataRd && stsArm) begin
        doneFlag <= 1'b0;
        ovrFlag  <= 1'b0;
      end
      if (complete) begin
        if (doneFlag) ovrFlag  <= 1'b1;
        else          doneFlag <= 1'b1;
      end
      if (faultNow)
        modfFlag <= 1'b1;
      else if (ctrlWr && stsArm && modfFlag)
        modfFlag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      ADDR_CTRL: rdData = DATA_W'({rate, masterOn, spiOn});
      ADDR_STAT: rdData = DATA_W'({modfFlag, ovrFlag, doneFlag});
      ADDR_DATA: rdData = rxByte;
      default:   rdData = '0;
    endcase
  end

  // R9
  modeFault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spiOn && masterOn && !ssSync) |=> (modfFlag && !spiOn && !masterOn && !mstBusy));

  // R10
  enableLock_chk: assert property (@(posedge clk) disable iff (!rstN)
    modfFlag |-> !spiOn);

  // R7
  overrunKeep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (complete && doneFlag) |=> (ovrFlag && $stable(rxByte)));

  // R3
  sckIdle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mstBusy |-> !sckOut);

endmodule

// File: rtl/spiDuplexCore.sv
module spiDuplexCore
  import spiPkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int DIV_W  = 5,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              ssN
);

  spiStrobe_t        str;
  logic              spiOn, masterOn, mstBusy;
  logic              sckRise, sckFall, ssSync;
  logic [DATA_W-1:0] rxByte;

  spiCtrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .ctrlBits (wrData[3:0]),
    .ssSync   (ssSync),
    .sckRise  (sckRise),
    .sckFall  (sckFall),
    .rxByte   (rxByte),
    .rdData   (rdData),
    .str      (str),
    .spiOn    (spiOn),
    .masterOn (masterOn),
    .mstBusy  (mstBusy),
    .sckOut   (sckOut)
  );

  spiDatapath #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .str      (str),
    .masterOn (masterOn),
    .mstBusy  (mstBusy),
    .txByte   (wrData),
    .sckIn    (sckIn),
    .mosiIn   (mosiIn),
    .misoIn   (misoIn),
    .ssN      (ssN),
    .sckRise  (sckRise),
    .sckFall  (sckFall),
    .ssSync   (ssSync),
    .rxByte   (rxByte),
    .mosiOut  (mosiOut),
    .misoOut  (misoOut)
  );

  assign sckOe  = spiOn & masterOn;
  assign mosiOe = spiOn & masterOn;
  assign misoOe = spiOn & ~masterOn & ~ssSync;

endmodule

// File: tb/spiDuplexCore_tb_top.sv
module spiDuplexCore_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = 8'h00, rdData;
  logic       sckIn = 1'b0, sckOut, sckOe;
  logic       mosiIn = 1'b0, mosiOut, mosiOe;
  logic       misoIn = 1'b0, misoOut, misoOe;
  logic       ssN = 1'b1;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] expQ[$];
  logic [7:0] slvReply = 8'h00;
  logic [7:0] mosiCap = 8'h00;
  int highCnt = 0;

  always #2 clk = ~clk;

  spiDuplexCore dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe),
    .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe),
    .ssN(ssN)
  );

  // Bench slave model seen by the master
  always @(negedge sckOut) begin
    slvReply = {slvReply[6:0], 1'b0};
    misoIn   = slvReply[7];
  end
  always @(posedge sckOut) mosiCap = {mosiCap[6:0], mosiOut};
  always @(negedge clk) if (sckOut) highCnt++;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  // Monitor: pops the next expected byte and compares with the data register
  task automatic monitorRx(input string req);
    logic [7:0] got;
    busRead(2'd2, got);
    if (expQ.size() == 0) begin
      check({req, " queue empty"}, 1, 0);
    end else begin
      check(req, got, expQ.pop_front());
    end
  endtask

  // Driver: one master exchange, optionally with a write during the transfer
  task automatic masterXfer(input logic [7:0] tx, input logic [7:0] reply,
                            input int half, input bit midWrite, input string req);
    logic [7:0] st;
    slvReply = reply; misoIn = reply[7]; mosiCap = 8'h00;
    expQ.push_back(reply);
    busWrite(2'd2, tx);
    highCnt = 0;
    if (midWrite) busWrite(2'd2, 8'hFF);
    st = 8'h00;
    for (int k = 0; k < 400 && !st[0]; k++) busRead(2'd1, st);
    check({req, " done"}, st[0], 1);
    check({req, " mosi bits"}, mosiCap, tx);
    check({req, " sck high cycles"}, highCnt, 8 * half);
    check({req, " sck idle"}, sckOut, 0);
    check({req, " mosi idle"}, mosiOut, 0);
    monitorRx({req, " rx byte"});
  endtask

  task automatic slaveByte(input logic [7:0] tx, output logic [7:0] cap);
    cap = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      mosiIn = tx[i];
      repeat (6) @(negedge clk);
      sckIn = 1'b1;
      cap = {cap[6:0], misoOut};
      repeat (6) @(negedge clk);
      sckIn = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, cap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sckOut", sckOut, 0);
    check("R1 enables", {sckOe, mosiOe, misoOe}, 0);
    busRead(2'd0, r); check("R1 control", r, 8'h00);
    busRead(2'd1, r); check("R1 status", r, 8'h00);

    // R2 control readback, master at rate 1
    busWrite(2'd0, 8'h07);
    busRead(2'd0, r); check("R2 control readback", r, 8'h07);
    // R11 master enables
    check("R11 master oe", {sckOe, mosiOe, misoOe}, 3'b110);

    // R3/R4 exchanges at all rates
    masterXfer(8'hA5, 8'h3C, 2, 0, "R3 rate1");
    busWrite(2'd0, 8'h03);
    masterXfer(8'h81, 8'h7E, 1, 0, "R4 rate0");
    busWrite(2'd0, 8'h0B);
    masterXfer(8'h5A, 8'hC1, 8, 0, "R4 rate2");
    busWrite(2'd0, 8'h0F);
    masterXfer(8'h0F, 8'hF0, 16, 0, "R4 rate3");
    busRead(2'd1, r); check("R8 status cleared after reads", r, 8'h00);

    // R5 write during transfer ignored
    busWrite(2'd0, 8'h07);
    masterXfer(8'hC6, 8'h99, 2, 1, "R5 busy write");

    // R9 mode fault during a transfer
    busWrite(2'd0, 8'h0F);
    slvReply = 8'h00;
    busWrite(2'd2, 8'hAA);
    repeat (20) @(negedge clk);
    ssN = 1'b0;
    repeat (4) @(negedge clk);
    ssN = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 sck released", sckOut, 0);
    check("R11 fault oe", {sckOe, mosiOe}, 0);
    busWrite(2'd0, 8'h03);
    busRead(2'd0, r); check("R10 enable locked", r, 8'h02);
    busRead(2'd1, r); check("R9 status fault no done", r, 8'h04);
    busWrite(2'd0, 8'h03);
    busRead(2'd0, r); check("R10 clearing write keeps enable off", r, 8'h02);
    busRead(2'd1, r); check("R10 fault cleared", r, 8'h00);
    busWrite(2'd0, 8'h03);
    busRead(2'd0, r); check("R10 enable after clear", r, 8'h03);
    check("R9 master after fault control", {sckOe, mosiOe}, 2'b11);

    // R6 slave receive and transmit
    busWrite(2'd0, 8'h01);
    ssN = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 slave oe", {sckOe, mosiOe, misoOe}, 3'b001);
    busWrite(2'd2, 8'hC3);
    slaveByte(8'h5A, cap);
    check("R6 miso bits", cap, 8'hC3);
    busRead(2'd1, r); check("R6 done", r, 8'h01);
    // R7 overrun: second byte without reading the first
    slaveByte(8'h77, cap);
    busRead(2'd1, r); check("R7 overrun status", r, 8'h03);
    expQ.push_back(8'h5A);
    monitorRx("R7 unread byte kept");
    busRead(2'd1, r); check("R8 flags cleared", r, 8'h00);
    slaveByte(8'h11, cap);
    busRead(2'd1, r); check("R6 done again", r, 8'h01);
    expQ.push_back(8'h11);
    monitorRx("R6 slave rx byte");

    // R12 slave clock ignored while deselected
    ssN = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 miso off deselected", misoOe, 0);
    slaveByte(8'hE7, cap);
    busRead(2'd1, r); check("R12 no completion", r, 8'h00);
    busRead(2'd2, r); check("R12 data unchanged", r, 8'h11);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule